// File: doc/BRIEF.md
# UART FIFO Trigger-Level Interrupt Controller

This block tracks how full the receive and transmit FIFOs of one UART channel are, using an occupancy counter for each. The FIFO storage itself is not part of it. A FIFO control write sets the receive trigger field and the transmit trigger field. A separate table-select write picks which threshold table converts those fields into numeric thresholds. Both directions always use the same table, and the table chosen last applies.

The block has two level interrupt outputs. The receive request is asserted while the receive occupancy is at or above its threshold. The transmit request is asserted when the transmit occupancy has fallen below its threshold. There is one exception: if the last refill never took the FIFO above the threshold, the transmit request waits until the FIFO is completely empty.

The FIFO control write can also flush either counter. A flush is a one-cycle action, so no reset bit is held anywhere after it takes effect.

Top module: `uart_fifo_trig_ctrl`

## Requirements
- R1: After synchronous reset, both counts are 0, all trigger fields and the table choice are 0, so both thresholds are 1, `rx_irq` is 0 and `tx_irq` is 1.
- R2: A push strobe raises a count by one and a pop strobe lowers it by one. A push and a pop in the same cycle leave the count unchanged. The new count is visible on the cycle after the strobe.
- R3: A count never exceeds 64. A push into a full FIFO without a pop is ignored. A pop from an empty FIFO is ignored, and a push together with that pop still counts.
- R4: With the standard table, the receive field (`fcr_wdata[7:6]`) values 0, 1, 2 and 3 give receive thresholds 1, 4, 8 and 14. The transmit threshold is always 1.
- R5: When `tsel_wdata[5:4]` is written as 01, the enhanced table is used. It gives receive thresholds 8, 16, 24 and 28 and transmit thresholds (field `fcr_wdata[5:4]`) 16, 8, 24 and 30. Any other value written selects the standard table.
- R6: A single stored table choice serves both directions. A table-select write changes both thresholds from the next cycle on, and the trigger fields stored earlier are kept.
- R7: An FCR write updates the transmit field only while `efr_en` is 1. Otherwise the field keeps its previous value. The receive field is updated on every FCR write.
- R8: `rx_irq` is high exactly while the receive count is greater than or equal to the receive threshold.
- R9: The block keeps a record of whether the transmit count has exceeded the threshold since the FIFO was last empty. It is cleared when the count is 0. While it is set, `tx_irq` = count < threshold. While it is clear, `tx_irq` = count == 0.
- R10: An FCR write with bits 0 and 1 both set clears the receive count on the next cycle, overriding any push in that cycle. Bit 1 without bit 0 has no effect.
- R11: An FCR write with bits 0 and 2 both set clears the transmit count and its refill record. The receive count is not affected. Bit 2 without bit 0 has no effect.
- R12: The flush bits are not stored. A later FCR write without them leaves both counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fcr_we | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write data (trigger fields, enable, flush bits) |
| tsel_we | input | 1 | Table-select write strobe |
| tsel_wdata | input | 8 | Table-select write data, bits 5:4 choose the table |
| efr_en | input | 1 | Enhanced-feature enable, unlocks the transmit trigger field |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| rx_count | output | 7 | Receive occupancy |
| tx_count | output | 7 | Transmit occupancy |
| rx_irq | output | 1 | Receive trigger request, level |
| tx_irq | output | 1 | Transmit trigger request, level |

## Verification
The bench drains a transmit FIFO that was filled to only 10 entries while the threshold is 16. A design that ignored the refill record would raise `tx_irq` at 10 instead of at 0. The bench also writes the transmit field with `efr_en` low and then checks the threshold the FIFO behaves against, which catches a design that does not guard that field.

It issues flush bits without the enable bit and a flush together with a push, so a design that flushes without the enable bit, or lets the push win, shows up as a wrong count. It also toggles the table while the transmit FIFO is partly full, pushes past 64 and pops from empty. A design that keeps a separate table per direction, or wraps its counters, would report the wrong interrupt level or count.

// File: rtl/uft_pkg.sv
// Shared types for the UART FIFO trigger controller.
package uft_pkg;
    // Stored trigger configuration: field selectors and the shared table choice.
    typedef struct packed {
        logic [1:0] rx_sel;  // receive trigger field
        logic [1:0] tx_sel;  // transmit trigger field
        logic       enh;     // 1 = enhanced table, 0 = standard table
    } trig_cfg_t;
endpackage

// File: rtl/uft_cfg_regs.sv
// Configuration registers: holds trigger fields and table choice, and turns
// FIFO control writes into one-cycle flush pulses.
// Assumes: write strobes are single-cycle qualified; nothing is kept of the flush bits.
module uft_cfg_regs
    import uft_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fcr_we,
    input  logic [7:0] fcr_wdata,
    input  logic       tsel_we,
    input  logic [7:0] tsel_wdata,
    input  logic       efr_en,
    output trig_cfg_t  cfg,
    output logic       rx_flush,
    output logic       tx_flush
);
    localparam int EN_BIT    = 0;
    localparam int RXRST_BIT = 1;
    localparam int TXRST_BIT = 2;

    // Capture trigger fields and the shared table choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else begin
            if (fcr_we) begin
                cfg.rx_sel <= fcr_wdata[7:6];
                if (efr_en) cfg.tx_sel <= fcr_wdata[5:4];
            end
            if (tsel_we) cfg.enh <= (tsel_wdata[5:4] == 2'b01);
        end
    end

    // Flush pulses exist only in the write cycle, so they clear themselves.
    always_comb begin
        rx_flush = fcr_we && fcr_wdata[EN_BIT] && fcr_wdata[RXRST_BIT];
        tx_flush = fcr_we && fcr_wdata[EN_BIT] && fcr_wdata[TXRST_BIT];
    end

    // R7: transmit field locked while the enhanced enable is low
    a_r7_tx_field_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_we && !efr_en) |=> $stable(cfg.tx_sel));
    // R6: table choice changes only through a table-select write
    a_r6_table_held: assert property (@(posedge clk) disable iff (!rst_n)
        !tsel_we |=> $stable(cfg.enh));
endmodule

// File: rtl/uft_occ_counter.sv
// Occupancy counter for one FIFO: saturating up/down count with a flush.
// Assumes: flush has priority over push and pop in the same cycle.
module uft_occ_counter #(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic inc, dec;

    // Qualify strobes: pop on empty dropped, push on full dropped unless a pop frees a slot.
    always_comb begin
        dec = pop && (count != '0);
        inc = push && ((count != FULL) || dec);
    end

    // Update the count.
    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '0;
        else if (flush)      count <= '0;
        else if (inc && !dec) count <= count + 1'b1;
        else if (dec && !inc) count <= count - 1'b1;
    end

    // R3: never beyond capacity
    a_r3_bounded: assert property (@(posedge clk) disable iff (!rst_n) count <= FULL);
    // R3: push into full FIFO is dropped
    a_r3_full_push: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL && push && !pop && !flush) |=> count == FULL);
    // R3: pop from empty FIFO is dropped
    a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop && !push && !flush) |=> count == '0);
    // R10 / R11: flush empties the counter
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);
endmodule

// File: rtl/uft_thresh_decode.sv
// Threshold decoder: maps stored trigger fields through the shared table.
// Assumes: thresholds fit in the counter width.
module uft_thresh_decode
    import uft_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  trig_cfg_t        cfg,
    output logic [CNT_W-1:0] rx_thr,
    output logic [CNT_W-1:0] tx_thr
);
    // Table lookup for both directions.
    always_comb begin
        if (cfg.enh) begin
            case (cfg.rx_sel)
                2'd0:    rx_thr = CNT_W'(8);
                2'd1:    rx_thr = CNT_W'(16);
                2'd2:    rx_thr = CNT_W'(24);
                default: rx_thr = CNT_W'(28);
            endcase
            case (cfg.tx_sel)
                2'd0:    tx_thr = CNT_W'(16);
                2'd1:    tx_thr = CNT_W'(8);
                2'd2:    tx_thr = CNT_W'(24);
                default: tx_thr = CNT_W'(30);
            endcase
        end else begin
            case (cfg.rx_sel)
                2'd0:    rx_thr = CNT_W'(1);
                2'd1:    rx_thr = CNT_W'(4);
                2'd2:    rx_thr = CNT_W'(8);
                default: rx_thr = CNT_W'(14);
            endcase
            tx_thr = CNT_W'(1);
        end
    end
endmodule

// File: rtl/uft_tx_irq_track.sv
// Transmit request logic: remembers whether the FIFO rose above the threshold
// since it was last empty, and picks the below-threshold or empty condition.
// Assumes: threshold is at least 1.
module uft_tx_irq_track #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thr,
    output logic             irq
);
    logic armed;

    // Track the refill record; emptiness clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)              armed <= 1'b0;
        else if (count == '0)    armed <= 1'b0;
        else if (count > thr)    armed <= 1'b1;
    end

    // Select the request condition.
    always_comb irq = armed ? (count < thr) : (count == '0);

    // R9: never requesting while above the threshold
    a_r9_quiet_above: assert property (@(posedge clk) disable iff (!rst_n)
        (count > thr) |-> !irq);
    // R9: an empty FIFO always requests
    a_r9_empty_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> irq);
endmodule

// File: rtl/uart_fifo_trig_ctrl.sv
// Top: FIFO trigger-level interrupt controller for one UART channel.
// Assumes: push/pop strobes reflect real FIFO accesses; outputs are level signals.
module uart_fifo_trig_ctrl
    import uft_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fcr_we,
    input  logic [7:0]       fcr_wdata,
    input  logic             tsel_we,
    input  logic [7:0]       tsel_wdata,
    input  logic             efr_en,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             tx_push,
    input  logic             tx_pop,
    output logic [CNT_W-1:0] rx_count,
    output logic [CNT_W-1:0] tx_count,
    output logic             rx_irq,
    output logic             tx_irq
);
    trig_cfg_t        cfg;
    logic             rx_flush, tx_flush;
    logic [CNT_W-1:0] rx_thr, tx_thr;

    uft_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n),
        .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
        .tsel_we(tsel_we), .tsel_wdata(tsel_wdata),
        .efr_en(efr_en), .cfg(cfg),
        .rx_flush(rx_flush), .tx_flush(tx_flush)
    );

    uft_occ_counter #(.DEPTH(DEPTH)) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
        .flush(rx_flush), .count(rx_count)
    );

    uft_occ_counter #(.DEPTH(DEPTH)) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_pop),
        .flush(tx_flush), .count(tx_count)
    );

    uft_thresh_decode #(.CNT_W(CNT_W)) u_dec (
        .cfg(cfg), .rx_thr(rx_thr), .tx_thr(tx_thr)
    );

    uft_tx_irq_track #(.CNT_W(CNT_W)) u_txirq (
        .clk(clk), .rst_n(rst_n), .count(tx_count), .thr(tx_thr), .irq(tx_irq)
    );

    // Receive request: level while occupancy meets the threshold.
    always_comb rx_irq = (rx_count >= rx_thr);

    // R8: an empty receive FIFO never requests
    a_r8_rx_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> !rx_irq);
    // R10: a receive flush lowers the request next cycle
    a_r10_flush_drops_rx: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> !rx_irq);
    // R11: a transmit flush leaves the receive count alone
    a_r11_rx_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && !rx_flush && !rx_push && !rx_pop) |=> $stable(rx_count));
endmodule

// File: tb/tb_uart_fifo_trig_ctrl.sv
module tb_uart_fifo_trig_ctrl;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fcr_we = 0, tsel_we = 0, efr_en = 0;
    logic [7:0] fcr_wdata = '0, tsel_wdata = '0;
    logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
    logic [6:0] rx_count, tx_count;
    logic       rx_irq, tx_irq;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        int    rx_c;
        int    tx_c;
        bit    rx_i;
        bit    tx_i;
        string tag;
    } exp_t;
    exp_t sb[$];

    // model state
    int m_rx = 0, m_tx = 0;
    int m_rxsel = 0, m_txsel = 0;
    bit m_enh = 0, m_armed = 0;

    always #4 clk = ~clk;  // 125 MHz

    uart_fifo_trig_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
        .tsel_we(tsel_we), .tsel_wdata(tsel_wdata), .efr_en(efr_en),
        .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
        .rx_count(rx_count), .tx_count(tx_count), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    function automatic int rx_thr_f(bit enh, int sel);
        int std_t[4] = '{1, 4, 8, 14};
        int enh_t[4] = '{8, 16, 24, 28};
        return enh ? enh_t[sel] : std_t[sel];
    endfunction

    function automatic int tx_thr_f(bit enh, int sel);
        int enh_t[4] = '{16, 8, 24, 30};
        return enh ? enh_t[sel] : 1;
    endfunction

    function automatic int next_cnt(int c, bit pu, bit po, bit fl);
        bit d, i;
        if (fl) return 0;
        d = po && (c > 0);
        i = pu && ((c < DEPTH) || d);
        return c + int'(i) - int'(d);
    endfunction

    task automatic check(string tag, int a_rc, int e_rc, int a_tc, int e_tc,
                         bit a_ri, bit e_ri, bit a_ti, bit e_ti);
        n_checks++;
        if (a_rc != e_rc || a_tc != e_tc || a_ri != e_ri || a_ti != e_ti) begin
            n_fail++;
            $display("FAIL %s: rx_count=%0d exp %0d tx_count=%0d exp %0d rx_irq=%0d exp %0d tx_irq=%0d exp %0d",
                     tag, a_rc, e_rc, a_tc, e_tc, a_ri, e_ri, a_ti, e_ti);
        end
    endtask

    // driver: apply one cycle of stimulus and queue the expected result
    task automatic step(bit fw, logic [7:0] fd, bit tw, logic [7:0] td, bit ef,
                        bit rpu, bit rpo, bit tpu, bit tpo, string tag);
        exp_t e;
        int thr_old;
        bit rfl, tfl;
        @(negedge clk);
        fcr_we = fw; fcr_wdata = fd; tsel_we = tw; tsel_wdata = td; efr_en = ef;
        rx_push = rpu; rx_pop = rpo; tx_push = tpu; tx_pop = tpo;
        thr_old = tx_thr_f(m_enh, m_txsel);
        m_armed = (m_tx == 0) ? 1'b0 : (m_armed || (m_tx > thr_old));
        rfl = fw && fd[0] && fd[1];
        tfl = fw && fd[0] && fd[2];
        if (fw) begin
            m_rxsel = int'(fd[7:6]);
            if (ef) m_txsel = int'(fd[5:4]);
        end
        if (tw) m_enh = (td[5:4] == 2'b01);
        m_rx = next_cnt(m_rx, rpu, rpo, rfl);
        m_tx = next_cnt(m_tx, tpu, tpo, tfl);
        e.rx_c = m_rx;
        e.tx_c = m_tx;
        e.rx_i = (m_rx >= rx_thr_f(m_enh, m_rxsel));
        e.tx_i = m_armed ? (m_tx < tx_thr_f(m_enh, m_txsel)) : (m_tx == 0);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(string tag);             step(0, 8'h00, 0, 8'h00, 0, 0, 0, 0, 0, tag); endtask
    task automatic rxpush(int n, string tag);    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 8'h00, 0, 1, 0, 0, 0, tag); endtask
    task automatic rxpop(int n, string tag);     for (int i = 0; i < n; i++) step(0, 8'h00, 0, 8'h00, 0, 0, 1, 0, 0, tag); endtask
    task automatic txpush(int n, string tag);    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 8'h00, 0, 0, 0, 1, 0, tag); endtask
    task automatic txpop(int n, string tag);     for (int i = 0; i < n; i++) step(0, 8'h00, 0, 8'h00, 0, 0, 0, 0, 1, tag); endtask
    task automatic fcr(logic [7:0] d, bit ef, string tag) ; step(1, d, 0, 8'h00, ef, 0, 0, 0, 0, tag); endtask
    task automatic tsel(logic [7:0] d, string tag);      step(0, 8'h00, 1, d, 0, 0, 0, 0, 0, tag); endtask

    // monitor: compare outputs against the queued expectations, away from the edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, int'(rx_count), e.rx_c, int'(tx_count), e.tx_c,
                  rx_irq, e.rx_i, tx_irq, e.tx_i);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", int'(rx_count), 0, int'(tx_count), 0, rx_irq, 1'b0, tx_irq, 1'b1);
        idle("R1");
        // R2: counting, simultaneous push/pop
        rxpush(3, "R2");
        rxpop(1, "R2");
        step(0, 8'h00, 0, 8'h00, 0, 1, 1, 0, 0, "R2");
        txpush(2, "R2");
        step(0, 8'h00, 0, 8'h00, 0, 0, 0, 1, 1, "R2");
        txpop(2, "R2");
        rxpop(2, "R2");
        // R3: pop on empty, push+pop on empty
        rxpop(2, "R3");
        step(0, 8'h00, 0, 8'h00, 0, 1, 1, 0, 0, "R3");
        rxpop(1, "R3");
        // R4 / R8: standard receive thresholds
        fcr(8'h40, 0, "R4");
        rxpush(5, "R8");
        fcr(8'h80, 0, "R4");
        rxpush(4, "R8");
        fcr(8'hC0, 0, "R4");
        rxpush(6, "R8");
        // R3: saturation at 64
        rxpush(55, "R3");
        step(0, 8'h00, 0, 8'h00, 0, 1, 1, 0, 0, "R3");
        // R10: flush needs enable bit; flush beats push
        fcr(8'hC2, 0, "R10");
        step(1, 8'hC3, 0, 8'h00, 0, 1, 0, 0, 0, "R10");
        // R12: flush bit not retained
        rxpush(3, "R12");
        fcr(8'hC1, 0, "R12");
        // R5: enhanced table, receive threshold 28
        tsel(8'h10, "R5");
        rxpush(26, "R5");
        // R7: transmit field locked without enable -> stays 16
        fcr(8'hF1, 0, "R7");
        // R9: shallow refill requests only at empty
        txpush(10, "R9");
        txpop(10, "R9");
        // R9: deep refill requests below threshold
        txpush(20, "R9");
        txpop(6, "R9");
        txpop(14, "R9");
        // R7: unlocked write -> 30
        fcr(8'hF1, 1, "R7");
        txpush(31, "R7");
        txpop(2, "R7");
        // R6: switch to standard table then back
        tsel(8'h20, "R6");
        idle("R6");
        tsel(8'h10, "R6");
        idle("R6");
        // R11: transmit flush, receive untouched; no effect without enable
        fcr(8'hF5, 1, "R11");
        txpush(3, "R11");
        fcr(8'h04, 0, "R11");
        txpop(3, "R11");
        // R3: transmit saturation
        txpush(66, "R3");
        idle("R3");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule